// File: doc/BRIEF.md
# I-Structure Cell Memory

This block is a memory of 16-bit cells for a dataflow machine. Each cell also carries a presence state and an ownership bit. Requests arrive one at a time on a valid/ready port. Each request carries:
- an opcode,
- a cell address,
- two operand words (left and right),
- a flag that says whether the address came from the instruction's constant field,
- the destination tag that any result must be sent back to.

Results leave as tokens on a second valid/ready port, each one paired with a destination tag.

A read of a cell that holds no value is not answered at once. The cell becomes WAITING and keeps the reader's tag. When a write later fills the cell, the block sends the reply to that stored tag. Each cell can hold only one deferred reader. The block also provides clear, allocate and free. It provides three atomic operations as well: read-then-increment, read-then-decrement and compare-and-swap. Misuse raises a one-cycle error pulse and is otherwise handled as each requirement states.

Top module: `istruct_mem`

## Requirements
- R1: After reset, no response is pending, `err` is low, `req_ready` is high, and every cell is EMPTY and not owned.
- R2: A read (op 0) of a FULL cell returns the stored value with the request tag. The response appears one cycle after the request is accepted, and the cell is unchanged.
- R3: A read of an EMPTY cell produces no response. The cell becomes WAITING and stores the tag. A read of a WAITING cell raises `err`, produces no response and keeps the first tag.
- R4: For a write (op 1) with `req_has_const`=1, the cell is `req_addr` and the data is `req_left`. With `req_has_const`=0, the cell is the low address bits of `req_left` and the data is `req_right`. All other ops take the cell from `req_addr`.
- R5: A write leaves the cell FULL with the new value. If the cell was WAITING, the block responds one cycle later with the written value and the stored tag. If the cell was FULL, it raises `err` and still overwrites. If the cell was EMPTY, the write is silent.
- R6: Clear (op 2) makes the cell EMPTY, discards any deferred reader and gives no response.
- R7: Alloc (op 3) sets the owned bit and makes the cell EMPTY, raising `err` if the cell was already owned. Free (op 4) clears the owned bit and makes the cell EMPTY, raising `err` if the cell was not owned. Neither op responds.
- R8: Read-increment (op 5) and read-decrement (op 6) on a FULL cell return the old value and store the old value plus or minus one, wrapping modulo 2^16. On a cell that is not FULL they raise `err`, give no response and change nothing.
- R9: Compare-and-swap (op 7) on a FULL cell returns the old value and stores `req_right` only when the old value equals `req_left`. On a cell that is not FULL it raises `err`, gives no response and changes nothing.
- R10: `err` is a one-cycle pulse in the cycle after an erroneous request is accepted, and is low at all other times.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` is low. Otherwise `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 3 | Opcode (see R2 to R9) |
| req_has_const | input | 1 | Address came from the constant field |
| req_addr | input | ADDR_W | Cell address from the constant field |
| req_left | input | 16 | Left operand |
| req_right | input | 16 | Right operand |
| req_tag | input | TAG_W | Return destination tag |
| rsp_valid | output | 1 | Result token present |
| rsp_ready | input | 1 | Result token taken |
| rsp_data | output | 16 | Result value |
| rsp_tag | output | TAG_W | Result destination tag |
| err | output | 1 | Misuse pulse |

## Verification
A corrupted presence state shows up at the ports within one request that touches the cell. A read that should answer stays silent, a write answers when it should not, or `err` pulses or fails to pulse. A lost deferred tag or a wrong stored value shows up on the next write or read of that cell, as a wrong `rsp_tag` or `rsp_data` one cycle after acceptance. The sweep runs thousands of mixed operations over a small memory and checks every request against an arithmetic model, so a fault appears after at most one further access to the cell.

// File: rtl/istruct_pkg.sv
package istruct_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_CLEAR = 3'd2,
    OP_ALLOC = 3'd3,
    OP_FREE  = 3'd4,
    OP_RDINC = 3'd5,
    OP_RDDEC = 3'd6,
    OP_CMPSW = 3'd7
  } ism_op_e;

  typedef enum logic [1:0] {
    CS_EMPTY = 2'd0,
    CS_FULL  = 2'd1,
    CS_WAIT  = 2'd2
  } cell_st_e;
endpackage

// File: rtl/ism_cell_array.sv
module ism_cell_array
  import istruct_pkg::*;
#(
  parameter int CELLS  = 256,
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  cell_st_e             wr_state,
  input  logic                 wr_own,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [TAG_W-1:0]     wr_tag,
  output cell_st_e             rd_state,
  output logic                 rd_own,
  output logic [WORD_W-1:0]    rd_data,
  output logic [TAG_W-1:0]     rd_tag
);
  cell_st_e          st_all  [CELLS];
  logic              own_all [CELLS];
  logic [WORD_W-1:0] dat_all [CELLS];
  logic [TAG_W-1:0]  tag_all [CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    cell_st_e          st_q;
    logic              own_q;
    logic [WORD_W-1:0] dat_q;
    logic [TAG_W-1:0]  tag_q;
    logic              hit;

    assign hit = wr_en && (addr == ADDR_W'(i));

    // presence and ownership: reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= CS_EMPTY;
        own_q <= 1'b0;
      end else if (hit) begin
        st_q  <= wr_state;
        own_q <= wr_own;
      end
    end

    // payload: no reset
    always_ff @(posedge clk) begin
      if (hit) begin
        dat_q <= wr_data;
        tag_q <= wr_tag;
      end
    end

    assign st_all[i]  = st_q;
    assign own_all[i] = own_q;
    assign dat_all[i] = dat_q;
    assign tag_all[i] = tag_q;
  end

  assign rd_state = st_all[addr];
  assign rd_own   = own_all[addr];
  assign rd_data  = dat_all[addr];
  assign rd_tag   = tag_all[addr];
endmodule

// File: rtl/ism_exec.sv
module ism_exec
  import istruct_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  ism_op_e            op,
  input  logic               has_const,
  input  logic [WORD_W-1:0]  left,
  input  logic [WORD_W-1:0]  right,
  input  logic [TAG_W-1:0]   tag,
  input  cell_st_e           cur_state,
  input  logic               cur_own,
  input  logic [WORD_W-1:0]  cur_data,
  input  logic [TAG_W-1:0]   cur_tag,
  output cell_st_e           nxt_state,
  output logic               nxt_own,
  output logic [WORD_W-1:0]  nxt_data,
  output logic [TAG_W-1:0]   nxt_tag,
  output logic               rsp_en,
  output logic [WORD_W-1:0]  rsp_data,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic               bad
);
  logic [WORD_W-1:0] wdata;
  logic              full;

  assign wdata = has_const ? left : right;
  assign full  = (cur_state == CS_FULL);

  always_comb begin
    nxt_state = cur_state;
    nxt_own   = cur_own;
    nxt_data  = cur_data;
    nxt_tag   = cur_tag;
    rsp_en    = 1'b0;
    rsp_data  = cur_data;
    rsp_tag   = tag;
    bad       = 1'b0;
    unique case (op)
      OP_READ: begin
        if (full) begin
          rsp_en = 1'b1;
        end else if (cur_state == CS_EMPTY) begin
          nxt_state = CS_WAIT;
          nxt_tag   = tag;
        end else begin
          bad = 1'b1;
        end
      end
      OP_WRITE: begin
        nxt_state = CS_FULL;
        nxt_data  = wdata;
        bad       = full;
        if (cur_state == CS_WAIT) begin
          rsp_en   = 1'b1;
          rsp_data = wdata;
          rsp_tag  = cur_tag;
        end
      end
      OP_CLEAR: nxt_state = CS_EMPTY;
      OP_ALLOC: begin
        nxt_state = CS_EMPTY;
        nxt_own   = 1'b1;
        bad       = cur_own;
      end
      OP_FREE: begin
        nxt_state = CS_EMPTY;
        nxt_own   = 1'b0;
        bad       = !cur_own;
      end
      OP_RDINC, OP_RDDEC: begin
        if (full) begin
          rsp_en   = 1'b1;
          nxt_data = (op == OP_RDINC) ? cur_data + 1'b1 : cur_data - 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      OP_CMPSW: begin
        if (full) begin
          rsp_en = 1'b1;
          if (cur_data == left) nxt_data = right;
        end else begin
          bad = 1'b1;
        end
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ism_rsp_reg.sv
module ism_rsp_reg
  import istruct_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic [TAG_W-1:0]   ld_tag,
  input  logic               rsp_ready,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  output logic [TAG_W-1:0]   rsp_tag
);
  logic valid_d;
  logic pay_en;

  always_comb begin
    pay_en  = load;
    valid_d = rsp_valid;
    if (load)           valid_d = 1'b1;
    else if (rsp_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      rsp_data <= ld_data;
      rsp_tag  <= ld_tag;
    end
  end
endmodule

// File: rtl/istruct_mem.sv
module istruct_mem
  import istruct_pkg::*;
#(
  parameter int CELLS  = 256,
  parameter int TAG_W  = 8,
  localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic               req_has_const,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [15:0]        req_left,
  input  logic [15:0]        req_right,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [15:0]        rsp_data,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic               err
);
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  ism_op_e           op;
  logic              fire;
  logic [ADDR_W-1:0] cell_addr;
  cell_st_e          cur_state, nxt_state;
  logic              cur_own, nxt_own;
  logic [WORD_W-1:0] cur_data, nxt_data, x_data;
  logic [TAG_W-1:0]  cur_tag, nxt_tag, x_tag;
  logic              x_rsp, x_bad, err_d;

  assign op        = ism_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign cell_addr = (op == OP_WRITE && !req_has_const) ? req_left[ADDR_W-1:0] : req_addr;

  ism_cell_array #(.CELLS(CELLS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rst_n(rst_int), .addr(cell_addr), .wr_en(fire),
    .wr_state(nxt_state), .wr_own(nxt_own), .wr_data(nxt_data), .wr_tag(nxt_tag),
    .rd_state(cur_state), .rd_own(cur_own), .rd_data(cur_data), .rd_tag(cur_tag)
  );

  ism_exec #(.TAG_W(TAG_W)) u_exec (
    .op(op), .has_const(req_has_const), .left(req_left), .right(req_right), .tag(req_tag),
    .cur_state(cur_state), .cur_own(cur_own), .cur_data(cur_data), .cur_tag(cur_tag),
    .nxt_state(nxt_state), .nxt_own(nxt_own), .nxt_data(nxt_data), .nxt_tag(nxt_tag),
    .rsp_en(x_rsp), .rsp_data(x_data), .rsp_tag(x_tag), .bad(x_bad)
  );

  ism_rsp_reg #(.TAG_W(TAG_W)) u_rsp (
    .clk(clk), .rst_n(rst_int), .load(fire && x_rsp), .ld_data(x_data), .ld_tag(x_tag),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  assign err_d = fire && x_bad;
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) err <= 1'b0;
    else          err <= err_d;
  end
endmodule

// File: rtl/istruct_mem_chk.sv
module istruct_mem_chk
  import istruct_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic              clk,
  input logic              rst_int,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input cell_st_e          cur_state,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_data,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              err
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_int)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_int)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R6
  quiet_ops_chk: assert property (@(posedge clk) disable iff (!rst_int)
    acc && (req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd4) |=> !rsp_valid);

  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !acc |=> !err);

  // R8
  rmw_reply_chk: assert property (@(posedge clk) disable iff (!rst_int)
    acc && req_op >= 3'd5 && cur_state == CS_FULL |=> rsp_valid && !err);

  // R3
  second_reader_chk: assert property (@(posedge clk) disable iff (!rst_int)
    acc && req_op == 3'd0 && cur_state == CS_WAIT |=> err && !rsp_valid);
endmodule

bind istruct_mem istruct_mem_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_int(rst_int), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .cur_state(cur_state), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_tag(rsp_tag), .err(err)
);

// File: tb/istruct_mem_test.sv
`timescale 1ns/1ps
module istruct_mem_test;
  localparam int CELLS = 8;
  localparam int TW    = 4;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_has_const, rsp_valid, rsp_ready, err;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_left, req_right, rsp_data;
  logic [TW-1:0] req_tag, rsp_tag;

  always #4 clk = ~clk;

  istruct_mem #(.CELLS(CELLS), .TAG_W(TW)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // model: state 0 EMPTY, 1 FULL, 2 WAITING
  int          mst [CELLS];
  bit          mown[CELLS];
  logic [15:0] mdat[CELLS];
  logic [TW-1:0] mtag[CELLS];
  bit          ev, ee;
  logic [15:0] ed;
  logic [TW-1:0] et;

  task automatic check(input bit ok, input string lbl, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input bit hc, input logic [AW-1:0] a,
                       input logic [15:0] l, input logic [15:0] r, input logic [TW-1:0] tg);
    int c;
    logic [15:0] w;
    c = (op == 3'd1 && !hc) ? int'(l[AW-1:0]) : int'(a);
    w = hc ? l : r;
    ev = 0; ee = 0; ed = 0; et = tg;
    case (op)
      3'd0: if (mst[c] == 1) begin ev = 1; ed = mdat[c]; end
            else if (mst[c] == 0) begin mst[c] = 2; mtag[c] = tg; end
            else ee = 1;
      3'd1: begin
              if (mst[c] == 2) begin ev = 1; ed = w; et = mtag[c]; end
              if (mst[c] == 1) ee = 1;
              mst[c] = 1; mdat[c] = w;
            end
      3'd2: mst[c] = 0;
      3'd3: begin ee = mown[c]; mown[c] = 1; mst[c] = 0; end
      3'd4: begin ee = !mown[c]; mown[c] = 0; mst[c] = 0; end
      3'd5, 3'd6: if (mst[c] == 1) begin
              ev = 1; ed = mdat[c];
              mdat[c] = (op == 3'd5) ? mdat[c] + 16'd1 : mdat[c] - 16'd1;
            end else ee = 1;
      default: if (mst[c] == 1) begin
              ev = 1; ed = mdat[c];
              if (mdat[c] == l) mdat[c] = r;
            end else ee = 1;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2 R3";
      3'd1: return "R4 R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input bit hc, input logic [AW-1:0] a,
                     input logic [15:0] l, input logic [15:0] r, input logic [TW-1:0] tg);
    logic [31:0] act, exp;
    model(op, hc, a, l, r, tg);
    req_valid = 1; req_op = op; req_has_const = hc; req_addr = a;
    req_left = l; req_right = r; req_tag = tg;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    act = {10'd0, rsp_valid, err, (rsp_valid ? rsp_tag : 4'd0), (rsp_valid ? rsp_data : 16'd0)};
    exp = {10'd0, ev, ee, (ev ? et : 4'd0), (ev ? ed : 16'd0)};
    check(act == exp, {tag_of(op), " R10"}, act, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [15:0] v;
    logic [2:0]  op;
    logic [AW-1:0] a;
    logic [15:0] l;
    req_valid = 0; req_op = 0; req_has_const = 0; req_addr = 0;
    req_left = 0; req_right = 0; req_tag = 0; rsp_ready = 1;
    for (int i = 0; i < CELLS; i++) begin mst[i] = 0; mown[i] = 0; mdat[i] = 0; mtag[i] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    check(!rsp_valid && !err && req_ready, "R1", {29'd0, rsp_valid, err, req_ready}, 32'd1);

    // R3 R5: every cell deferred then filled by both addressing forms (R4)
    for (int i = 0; i < CELLS; i++) begin
      run(3'd0, 0, AW'(i), 16'd0, 16'd0, TW'(i));
      run(3'd0, 0, AW'(i), 16'd0, 16'd0, TW'(15 - i));
      if (i % 2 == 0) run(3'd1, 1, AW'(i), 16'h1234 + 16'(i), 16'hDEAD, 4'd0);
      else            run(3'd1, 0, 3'd0, 16'hFFF8 | 16'(i), 16'h0A00 + 16'(i), 4'd0);
      run(3'd0, 0, AW'(i), 16'd0, 16'd0, 4'd9);
    end
    // R8 wrap both directions
    run(3'd1, 1, 3'd2, 16'hFFFF, 16'd0, 4'd1);
    run(3'd5, 0, 3'd2, 16'd0, 16'd0, 4'd2);
    run(3'd0, 0, 3'd2, 16'd0, 16'd0, 4'd3);
    run(3'd6, 0, 3'd2, 16'd0, 16'd0, 4'd4);
    run(3'd0, 0, 3'd2, 16'd0, 16'd0, 4'd5);
    // R9 match and mismatch
    run(3'd7, 0, 3'd2, 16'hFFFF, 16'h0055, 4'd6);
    run(3'd7, 0, 3'd2, 16'h0000, 16'h0077, 4'd7);
    run(3'd0, 0, 3'd2, 16'd0, 16'd0, 4'd8);
    // R6 clear drops a waiting reader: following write is silent
    run(3'd2, 0, 3'd3, 16'd0, 16'd0, 4'd0);
    run(3'd0, 0, 3'd3, 16'd0, 16'd0, 4'd1);
    run(3'd2, 0, 3'd3, 16'd0, 16'd0, 4'd0);
    run(3'd1, 1, 3'd3, 16'h4444, 16'd0, 4'd0);
    // R7 alloc twice, free twice
    run(3'd3, 0, 3'd4, 16'd0, 16'd0, 4'd0);
    run(3'd3, 0, 3'd4, 16'd0, 16'd0, 4'd0);
    run(3'd4, 0, 3'd4, 16'd0, 16'd0, 4'd0);
    run(3'd4, 0, 3'd4, 16'd0, 16'd0, 4'd0);

    // R11 backpressure
    run(3'd1, 1, 3'd5, 16'hBEEF, 16'd0, 4'd0);
    run(3'd1, 1, 3'd5, 16'hBEEF, 16'd0, 4'd0);
    rsp_ready = 0;
    req_valid = 1; req_op = 3'd0; req_addr = 3'd5; req_tag = 4'd6; req_has_const = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_data == 16'hBEEF && rsp_tag == 4'd6, "R11", {rsp_valid, rsp_tag, rsp_data}, {1'b1, 4'd6, 16'hBEEF});
    check(!req_ready, "R11", {31'd0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_data == 16'hBEEF && rsp_tag == 4'd6 && !req_ready, "R11",
          {req_ready, rsp_valid, rsp_tag, rsp_data}, {2'b01, 4'd6, 16'hBEEF});
    rsp_ready = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11", {30'd0, rsp_valid, req_ready}, 32'd1);

    // sweep of mixed ops
    s = 32'h1ACE5EED;
    for (int k = 0; k < 4000; k++) begin
      s = s * 32'd1103515245 + 32'd12345;
      case (s[21:20])
        2'd0: v = 16'hFFFF;
        2'd1: v = 16'h0000;
        2'd2: v = s[15:0];
        default: v = 16'h0001;
      endcase
      op = s[18:16];
      a  = s[25:23];
      l  = v;
      if (op == 3'd1 && !s[26]) l = (v & 16'hFFF8) | 16'(a);
      if (op == 3'd7 && s[27]) l = mdat[a];
      run(op, s[26], a, l, s[15:0] ^ 16'h5A5A, s[31:28]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule